// File: doc/BRIEF.md
# Set/Clear Peripheral Clock Gate Controller

This block holds the on/off state of up to 64 peripheral clocks, split into two banks of 32, and drives one gate-enable line per clock. Software never rewrites the whole gate word. Instead, each bank has a set port and a clear port. Writing ones to the set port ungates exactly those clocks, and writing ones to the clear port gates exactly those. Every clock not named in the write keeps its state, so two software agents can toggle different clocks without a lock.

The requested state can be read back at once. The gate-enable outputs and the bank status word follow the requested state through a fixed synchronizer delay. Software polls the status bit of a clock until it shows the new value, and only then treats the operation as complete.

Top module: `clkgate_ctrl`

## Requirements
- R1: Bank b (0 or 1) decodes four word addresses, each at bank base 0x24 + 0x10*b. The set port is at base+0x0, the clear port at base+0x4, the request word at base+0x8 and the status word at base+0xC.
- R2: A write to a bank's set port turns on every request bit whose data bit is 1. It leaves every other request bit of both banks unchanged, so a data word of zero has no effect.
- R3: A write to a bank's clear port turns off every request bit whose data bit is 1. It leaves every other request bit of both banks unchanged.
- R4: Clock ID n (0..63) belongs to bank n/32 at bit n mod 32, and drives output gateEn[n].
- R5: A write takes effect on the request word at the clock edge that accepts it. gateEn and the status word show the new value exactly two edges later, so between those edges status and request may differ.
- R6: After reset only clock ID 2 is enabled. Bank 0 request and status read 0x00000004, bank 1 reads zero, and gateEn equals 64'h4.
- R7: Reads of a set or clear port return zero, and reads of any address outside the eight decoded ones return zero.
- R8: Writes to a request word, a status word or an undecoded address change neither request state nor gateEn.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Active-low synchronous reset |
| busSel | input | 1 | Register access this cycle |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | 8 | Byte address of the register |
| busWdata | input | 32 | Write data, one bit per clock of the bank |
| busRdata | output | 32 | Read data, valid in the same cycle as the read |
| gateEn | output | 64 | Gate enable per clock ID, 1 = clock running |

## Verification
Every one of the 64 clock IDs is switched on and then off through single-bit writes. After each write, both full request words are compared with a model, which separates a wrong bank or bit mapping from a leak into neighbouring clocks. During each toggle, gateEn is sampled on the first, second and third cycle after the write, which pins the lag to exactly two edges. Dense mixed patterns, zero-data writes and writes to read-only or undecoded addresses then show that set and clear act only on the named bits and that the other addresses have no effect.

// File: rtl/clkgate_pkg.sv
package clkgate_pkg;
  localparam int GROUPS     = 2;
  localparam int GRP_BASE   = 'h24;
  localparam int GRP_STRIDE = 'h10;
  localparam int OFF_SET    = 'h0;
  localparam int OFF_CLR    = 'h4;
  localparam int OFF_REQ    = 'h8;
  localparam int OFF_STAT   = 'hC;

  // strobes from the decoder to the register bank
  typedef struct packed {
    logic [GROUPS-1:0] setHit;
    logic [GROUPS-1:0] clrHit;
    logic [GROUPS-1:0] reqRd;
    logic [GROUPS-1:0] statRd;
  } strobe_t;
endpackage

// File: rtl/clkgate_decode.sv
module clkgate_decode
  import clkgate_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              busSel,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  output strobe_t           stb
);
  always_comb begin
    stb = '0;
    for (int g = 0; g < GROUPS; g++) begin
      if (busSel && busWrite) begin
        stb.setHit[g] = (busAddr == ADDR_W'(GRP_BASE + g*GRP_STRIDE + OFF_SET));
        stb.clrHit[g] = (busAddr == ADDR_W'(GRP_BASE + g*GRP_STRIDE + OFF_CLR));
      end
      if (busSel && !busWrite) begin
        stb.reqRd[g]  = (busAddr == ADDR_W'(GRP_BASE + g*GRP_STRIDE + OFF_REQ));
        stb.statRd[g] = (busAddr == ADDR_W'(GRP_BASE + g*GRP_STRIDE + OFF_STAT));
      end
    end
  end
endmodule

// File: rtl/clkgate_bank.sv
module clkgate_bank
  import clkgate_pkg::*;
#(
  parameter int GRP_W       = 32,
  parameter int SYNC_STAGES = 2,
  parameter logic [GROUPS*GRP_W-1:0] RESET_MASK = 'h4
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  strobe_t                 stb,
  input  logic [GRP_W-1:0]        wrData,
  output logic [GROUPS*GRP_W-1:0] reqVec,
  output logic [GROUPS*GRP_W-1:0] statVec,
  output logic [GRP_W-1:0]        rdData
);
  for (genvar g = 0; g < GROUPS; g++) begin : g_grp
    localparam logic [GRP_W-1:0] RST_G = RESET_MASK[g*GRP_W +: GRP_W];
    logic [GRP_W-1:0] reqQ;
    logic [GRP_W-1:0] setM;
    logic [GRP_W-1:0] clrM;
    logic [GRP_W-1:0] syncQ [SYNC_STAGES];

    assign setM = stb.setHit[g] ? wrData : '0;
    assign clrM = stb.clrHit[g] ? wrData : '0;

    // clear is applied after set, so it has priority on a shared bit
    always_ff @(posedge clk) begin
      if (!rstN) reqQ <= RST_G;
      else       reqQ <= (reqQ | setM) & ~clrM;
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        for (int s = 0; s < SYNC_STAGES; s++) syncQ[s] <= RST_G;
      end else begin
        syncQ[0] <= reqQ;
        for (int s = 1; s < SYNC_STAGES; s++) syncQ[s] <= syncQ[s-1];
      end
    end

    assign reqVec[g*GRP_W +: GRP_W]  = reqQ;
    assign statVec[g*GRP_W +: GRP_W] = syncQ[SYNC_STAGES-1];
  end

  always_comb begin
    rdData = '0;
    for (int g = 0; g < GROUPS; g++) begin
      if (stb.reqRd[g])  rdData = rdData | reqVec[g*GRP_W +: GRP_W];
      if (stb.statRd[g]) rdData = rdData | statVec[g*GRP_W +: GRP_W];
    end
  end
endmodule

// File: rtl/clkgate_ctrl.sv
module clkgate_ctrl
  import clkgate_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int GRP_W       = 32,
  parameter int SYNC_STAGES = 2,
  parameter logic [GROUPS*GRP_W-1:0] RESET_MASK = 'h4
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    busSel,
  input  logic                    busWrite,
  input  logic [ADDR_W-1:0]       busAddr,
  input  logic [GRP_W-1:0]        busWdata,
  output logic [GRP_W-1:0]        busRdata,
  output logic [GROUPS*GRP_W-1:0] gateEn
);
  strobe_t                 stb;
  logic [GROUPS*GRP_W-1:0] reqVec;
  logic [GROUPS*GRP_W-1:0] statVec;

  clkgate_decode #(.ADDR_W(ADDR_W)) u_dec (
    .busSel(busSel), .busWrite(busWrite), .busAddr(busAddr), .stb(stb)
  );

  clkgate_bank #(.GRP_W(GRP_W), .SYNC_STAGES(SYNC_STAGES), .RESET_MASK(RESET_MASK)) u_bank (
    .clk(clk), .rstN(rstN), .stb(stb), .wrData(busWdata),
    .reqVec(reqVec), .statVec(statVec), .rdData(busRdata)
  );

  assign gateEn = statVec;
endmodule

// File: rtl/clkgate_chk.sv
module clkgate_chk
  import clkgate_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int GRP_W       = 32,
  parameter int SYNC_STAGES = 2
) (
  input logic                    clk,
  input logic                    rstN,
  input logic                    busSel,
  input logic                    busWrite,
  input logic [ADDR_W-1:0]       busAddr,
  input logic [GRP_W-1:0]        busWdata,
  input logic [GRP_W-1:0]        busRdata,
  input logic [GROUPS*GRP_W-1:0] gateEn,
  input logic [GROUPS*GRP_W-1:0] reqVec
);
  localparam logic [ADDR_W-1:0] SET0  = ADDR_W'(GRP_BASE + OFF_SET);
  localparam logic [ADDR_W-1:0] CLR0  = ADDR_W'(GRP_BASE + OFF_CLR);
  localparam logic [ADDR_W-1:0] REQ0  = ADDR_W'(GRP_BASE + OFF_REQ);
  localparam logic [ADDR_W-1:0] STAT0 = ADDR_W'(GRP_BASE + OFF_STAT);
  localparam logic [ADDR_W-1:0] SET1  = ADDR_W'(GRP_BASE + GRP_STRIDE + OFF_SET);
  localparam logic [ADDR_W-1:0] CLR1  = ADDR_W'(GRP_BASE + GRP_STRIDE + OFF_CLR);

  logic [1:0] sinceRst;
  always_ff @(posedge clk) begin
    if (!rstN)               sinceRst <= '0;
    else if (sinceRst != 2'd3) sinceRst <= sinceRst + 2'd1;
  end

  logic wr, rd;
  assign wr = busSel && busWrite;
  assign rd = busSel && !busWrite;

  // R2: bank 0 and bank 1 set ports
  assert_set_bank0_R2: assert property (@(posedge clk) disable iff (!rstN)
    (wr && busAddr == SET0) |=> reqVec[GRP_W-1:0] == ($past(reqVec[GRP_W-1:0]) | $past(busWdata)));
  assert_set_bank1_R2: assert property (@(posedge clk) disable iff (!rstN)
    (wr && busAddr == SET1) |=> reqVec[2*GRP_W-1:GRP_W] == ($past(reqVec[2*GRP_W-1:GRP_W]) | $past(busWdata)));
  // R3: bank 0 and bank 1 clear ports
  assert_clr_bank0_R3: assert property (@(posedge clk) disable iff (!rstN)
    (wr && busAddr == CLR0) |=> reqVec[GRP_W-1:0] == ($past(reqVec[GRP_W-1:0]) & ~$past(busWdata)));
  assert_clr_bank1_R3: assert property (@(posedge clk) disable iff (!rstN)
    (wr && busAddr == CLR1) |=> reqVec[2*GRP_W-1:GRP_W] == ($past(reqVec[2*GRP_W-1:GRP_W]) & ~$past(busWdata)));
  // R5: gate outputs trail the request by the synchronizer depth
  if (SYNC_STAGES == 2) begin : g_lag
    assert_gate_lag_R5: assert property (@(posedge clk) disable iff (!rstN)
      (sinceRst >= 2'd2) |-> gateEn == $past(reqVec, 2));
  end
  // R7: set and clear ports read as zero
  assert_port_reads_zero_R7: assert property (@(posedge clk) disable iff (!rstN)
    (rd && (busAddr == SET0 || busAddr == CLR0 || busAddr == SET1 || busAddr == CLR1)) |-> busRdata == '0);
  // R8: writes to read-only words leave request state alone
  assert_ro_write_ignored_R8: assert property (@(posedge clk) disable iff (!rstN)
    (wr && (busAddr == REQ0 || busAddr == STAT0)) |=> $stable(reqVec));
endmodule

bind clkgate_ctrl clkgate_chk #(.ADDR_W(ADDR_W), .GRP_W(GRP_W), .SYNC_STAGES(SYNC_STAGES)) u_chk (
  .clk(clk), .rstN(rstN), .busSel(busSel), .busWrite(busWrite), .busAddr(busAddr),
  .busWdata(busWdata), .busRdata(busRdata), .gateEn(gateEn), .reqVec(reqVec)
);

// File: tb/sim_clkgate_ctrl.sv
module sim_clkgate_ctrl;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busSel = 1'b0;
  logic        busWrite = 1'b0;
  logic [7:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [63:0] gateEn;

  int nChecks = 0;
  int nFails = 0;
  bit finished = 1'b0;
  logic [63:0] expReq;

  always #5 clk = ~clk;

  clkgate_ctrl u0 (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWrite(busWrite), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .gateEn(gateEn)
  );

  function automatic logic [7:0] regAddr(int bank, int off);
    return 8'(36 + 16*bank + off);
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic busWr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    busSel = 1'b1; busWrite = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busSel = 1'b0; busWrite = 1'b0;
  endtask

  task automatic busRd(logic [7:0] a, output logic [31:0] d);
    busSel = 1'b1; busWrite = 1'b0; busAddr = a;
    #1;
    d = busRdata;
    busSel = 1'b0;
  endtask

  task automatic chkReqWords(string req);
    logic [31:0] r0, r1;
    busRd(regAddr(0, 8), r0);
    busRd(regAddr(1, 8), r1);
    chk(req, {r1, r0}, expReq);
  endtask

  // toggles one ID and checks request, lag and status (R2..R5)
  task automatic toggleId(int id, bit on);
    logic [63:0] oldReq;
    logic [31:0] s0, s1;
    int bank = id / 32;
    oldReq = expReq;
    expReq[id] = on;
    busWr(regAddr(bank, on ? 0 : 4), 32'(1) << (id % 32));
    chkReqWords(on ? "R2/R4 request after set" : "R3/R4 request after clear");
    chk("R5 gate before first sync edge", gateEn, oldReq);
    @(negedge clk);
    chk("R5 gate after one edge", gateEn, oldReq);
    @(negedge clk);
    chk("R4/R5 gate after two edges", gateEn, expReq);
    busRd(regAddr(0, 12), s0);
    busRd(regAddr(1, 12), s1);
    chk("R1/R5 status words", {s1, s0}, expReq);
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    expReq = 64'h4;
    // R6 reset state
    chk("R6 gateEn at reset", gateEn, 64'h4);
    busRd(regAddr(0, 8), d);  chk("R6 bank0 request", {32'h0, d}, 64'h4);
    busRd(regAddr(0, 12), d); chk("R6 bank0 status", {32'h0, d}, 64'h4);
    busRd(regAddr(1, 8), d);  chk("R6 bank1 request", {32'h0, d}, 64'h0);
    busRd(regAddr(1, 12), d); chk("R6 bank1 status", {32'h0, d}, 64'h0);

    // R4 sweep: every ID on, then every ID off
    for (int id = 0; id < 64; id++) toggleId(id, 1'b1);
    for (int id = 0; id < 64; id++) toggleId(id, 1'b0);

    // R2/R3 dense patterns
    busWr(regAddr(0, 0), 32'hA5A5_5A5A); expReq[31:0]  |= 32'hA5A5_5A5A;
    busWr(regAddr(1, 0), 32'hFFFF_0000); expReq[63:32] |= 32'hFFFF_0000;
    chkReqWords("R2 pattern set");
    busWr(regAddr(0, 4), 32'h0F0F_0F0F); expReq[31:0]  &= ~32'h0F0F_0F0F;
    busWr(regAddr(1, 4), 32'h00FF_FF00); expReq[63:32] &= ~32'h00FF_FF00;
    chkReqWords("R3 pattern clear");
    busWr(regAddr(0, 0), 32'h0);
    busWr(regAddr(1, 4), 32'h0);
    chkReqWords("R2/R3 zero data no effect");
    @(negedge clk); @(negedge clk);
    chk("R5 gate settled on pattern", gateEn, expReq);

    // R7 reads of ports and undecoded addresses
    busRd(regAddr(0, 0), d); chk("R7 set port reads zero", {32'h0, d}, 64'h0);
    busRd(regAddr(0, 4), d); chk("R7 clear port reads zero", {32'h0, d}, 64'h0);
    busRd(regAddr(1, 0), d); chk("R7 set port reads zero", {32'h0, d}, 64'h0);
    busRd(regAddr(1, 4), d); chk("R7 clear port reads zero", {32'h0, d}, 64'h0);
    busRd(8'h00, d);         chk("R7 undecoded read", {32'h0, d}, 64'h0);
    busRd(8'h44, d);         chk("R7 undecoded read", {32'h0, d}, 64'h0);

    // R8 writes that must be ignored
    busWr(regAddr(0, 8), 32'hFFFF_FFFF);
    busWr(regAddr(0, 12), 32'hFFFF_FFFF);
    busWr(regAddr(1, 8), 32'h0);
    busWr(regAddr(1, 12), 32'hFFFF_FFFF);
    busWr(8'h20, 32'hFFFF_FFFF);
    busWr(8'h44, 32'hFFFF_FFFF);
    chkReqWords("R8 read-only writes ignored");
    @(negedge clk); @(negedge clk);
    chk("R8 gate unchanged", gateEn, expReq);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule